// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Core

This block holds the interrupt state of a single processor. It keeps three vector-wide bit arrays: the requested set, the in-service set and the level-trigger set. It also holds a task priority and derives a processor priority from that task priority and the highest in-service vector. From these it decides every cycle whether to raise a request line to the processor.

When the processor acknowledges, the block returns the highest requested vector and moves it from the requested set to the in-service set. If no vector clears the priority bar, the acknowledge returns a programmable spurious vector instead. An end-of-interrupt retires the highest in-service vector. If that vector was level-triggered and directed end-of-interrupt is off, the block emits a one-cycle broadcast pulse that carries the vector, so that the sources can re-arm.

A vector's priority class is its upper four bits. A higher vector number always wins.

Top module: `irq_prio_core`

## Requirements
- R1: A synchronous active-low reset clears all three arrays, the task priority and the configuration. After reset `irq_out` is 0, `ack_real` is 0 and the spurious vector is 0. A request made before the reset is lost.
- R2: A `set_req` sets the requested bit of `set_vec`. The level bit of that vector becomes `set_level` (1 means level, 0 means edge), so a later edge request for the same vector clears a level bit set earlier.
- R3: `irq_out` is 1 only while the configured enable (`cfg_enable` last written through `cfg_wr`) is 1 and at least one requested bit is set.
- R4: Among the requested vectors, the one with the highest index is offered and acknowledged first.
- R5: The processor priority is the task priority when the task priority's class is at least the class of the highest in-service vector. Otherwise it is that class followed by four zero bits, and an empty in-service set counts as class 0. A pending vector is offered only when the processor priority is 0 or the vector's class is strictly greater than the processor priority's class.
- R6: An acknowledge while a vector is offered returns that vector on `ack_vec` with `ack_real` = 1 in the same cycle. At the next clock edge it clears the vector's requested bit and sets its in-service bit.
- R7: An acknowledge while nothing is offered (held off, disabled or empty) returns the configured spurious vector with `ack_real` = 0 and changes no state.
- R8: An end-of-interrupt clears the highest set in-service bit in one clock. This may release a held-off request.
- R9: The end-of-interrupt broadcast is 1 in exactly the cycle after an end-of-interrupt that retired a level-triggered vector while directed end-of-interrupt (`cfg_dir_eoi`) is 0. It carries that vector, and it stays 0 otherwise.
- R10: An end-of-interrupt while the in-service set is empty has no effect: no broadcast, and pending requests are offered as before.
- R11: A task priority write stores `tp_val` as the upper four bits of the task priority with the lower four bits zero.
- R12: When a request and an acknowledge name the same vector in the same cycle, the vector becomes in service and also stays requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_req | input | 1 | Request strobe for `set_vec` |
| set_vec | input | VW | Vector being requested |
| set_level | input | 1 | Trigger of the request: 1 level, 0 edge |
| ack | input | 1 | Processor acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| tp_wr | input | 1 | Task priority write strobe |
| tp_val | input | 4 | Task priority class to store |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Software enable value |
| cfg_dir_eoi | input | 1 | Directed end-of-interrupt value (suppresses broadcast) |
| cfg_spur | input | VW | Spurious vector value |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_vec | output | VW | Vector returned for the acknowledge in this cycle |
| ack_real | output | 1 | 1 when `ack_vec` is a real vector being taken |
| eoi_bcast | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bcast_vec | output | VW | Vector carried by the broadcast |

## Verification
`irq_out`, `ack_vec` and `ack_real` are combinational. The bench reads them one step after driving the inputs at a falling edge, before the rising edge that commits the acknowledge. Requests, acknowledges, end-of-interrupts and register writes take effect at the next rising edge, so their effects are checked at the falling edge that follows. `eoi_bcast` is registered. The bench samples it at the falling edge after the end-of-interrupt edge, and one cycle later it checks that the pulse has dropped.

// File: rtl/irq_prio_pkg.sv
// Package: shared constants and types for the interrupt priority core.
// Assumes the vector width is at least the width of a priority class.
package irq_prio_pkg;

    // Width of a priority class, the upper bits of a vector.
    localparam int PRI_CLASS_W = 4;

    // Configuration flags held by the core.
    typedef struct packed {
        logic enable;   // software enable
        logic dir_eoi;  // directed end-of-interrupt, suppresses broadcast
    } cfg_flags_t;

endpackage

// File: rtl/vec_msb_find.sv
// Module: vec_msb_find
// Finds the highest set bit of a wide vector. First it finds the highest
// bit inside each word, then the highest non-empty word.
// Assumes NBITS is a multiple of WORD and WORD is at least 2.
module vec_msb_find #(
    parameter int NBITS = 256,
    parameter int WORD  = 32
) (
    input  logic [NBITS-1:0]         bits,
    output logic                     found,
    output logic [$clog2(NBITS)-1:0] idx
);
    localparam int NWORDS = NBITS / WORD;
    localparam int IW     = $clog2(NBITS);
    localparam int BW     = $clog2(WORD);

    logic [NWORDS-1:0] w_any;
    logic [BW-1:0]     w_idx [NWORDS];

    generate
        for (genvar w = 0; w < NWORDS; w++) begin : g_word
            logic          any_l;
            logic [BW-1:0] idx_l;

            // Highest set bit inside this word.
            always_comb begin
                any_l = |bits[w*WORD +: WORD];
                idx_l = '0;
                for (int b = 0; b < WORD; b++) begin
                    if (bits[w*WORD + b]) begin
                        idx_l = BW'(b);
                    end
                end
            end

            assign w_any[w] = any_l;
            assign w_idx[w] = idx_l;
        end
    endgenerate

    // Pick the highest non-empty word and join its index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (w_any[w]) begin
                found = 1'b1;
                idx   = IW'(w * WORD + int'(w_idx[w]));
            end
        end
    end
endmodule

// File: rtl/vec_bank.sv
// Module: vec_bank
// Holds the requested, in-service and level-trigger bit arrays.
// A request sets a requested bit and writes the level bit. A take moves a
// vector from requested to in service. A retire clears an in-service bit.
// A request wins over a take of the same vector in the same cycle.
module vec_bank #(
    parameter int NBITS = 256,
    parameter int IW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IW-1:0]    set_idx,
    input  logic             set_lvl,
    input  logic             take_en,
    input  logic [IW-1:0]    take_idx,
    input  logic             retire_en,
    input  logic [IW-1:0]    retire_idx,
    output logic [NBITS-1:0] req_q,
    output logic [NBITS-1:0] svc_q,
    output logic [NBITS-1:0] lvl_q
);
    logic [NBITS-1:0] set_m;
    logic [NBITS-1:0] take_m;
    logic [NBITS-1:0] retire_m;

    // Decode the one-hot masks of the three operations.
    always_comb begin
        set_m    = set_en    ? (NBITS'(1) << set_idx)    : '0;
        take_m   = take_en   ? (NBITS'(1) << take_idx)   : '0;
        retire_m = retire_en ? (NBITS'(1) << retire_idx) : '0;
    end

    // Update the three arrays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            svc_q <= '0;
            lvl_q <= '0;
        end else begin
            req_q <= (req_q & ~take_m) | set_m;
            svc_q <= (svc_q & ~retire_m) | take_m;
            lvl_q <= (lvl_q & ~set_m) | (set_lvl ? set_m : '0);
        end
    end
endmodule

// File: rtl/prio_eval.sv
// Module: prio_eval
// Derives the processor priority and decides whether the top request is
// offered. Pure combinational logic.
// Assumes the class is the upper PRI_CLASS_W bits of a vector.
module prio_eval
    import irq_prio_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic                   enable,
    input  logic [VW-1:0]          task_pri,
    input  logic                   svc_found,
    input  logic [PRI_CLASS_W-1:0] svc_cls,
    input  logic                   req_found,
    input  logic [PRI_CLASS_W-1:0] req_cls,
    output logic [VW-1:0]          cur_pri,
    output logic                   pending,
    output logic                   offer
);
    localparam int LW = VW - PRI_CLASS_W;

    logic [PRI_CLASS_W-1:0] svc_eff;
    logic                   held;

    // Processor priority from the task priority and the in-service class.
    always_comb begin
        svc_eff = svc_found ? svc_cls : '0;
        if (task_pri[VW-1:LW] >= svc_eff) begin
            cur_pri = task_pri;
        end else begin
            cur_pri = {svc_eff, {LW{1'b0}}};
        end
    end

    // The request is offered only above the processor priority class.
    always_comb begin
        pending = enable & req_found;
        held    = (cur_pri != '0) && (req_cls <= cur_pri[VW-1:LW]);
        offer   = pending & ~held;
    end
endmodule

// File: rtl/irq_prio_core.sv
// Module: irq_prio_core (top)
// Interrupt priority and acknowledge core for one processor: the vector
// arrays, the task priority, the configuration, and the acknowledge and
// end-of-interrupt handling. The request line is combinational. The
// broadcast pulse is registered one cycle after the end-of-interrupt.
// Assumes VW <= 8 and VW > PRI_CLASS_W.
module irq_prio_core
    import irq_prio_pkg::*;
#(
    parameter int VW   = 8,
    parameter int WORD = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_req,
    input  logic [VW-1:0]          set_vec,
    input  logic                   set_level,
    input  logic                   ack,
    input  logic                   eoi,
    input  logic                   tp_wr,
    input  logic [PRI_CLASS_W-1:0] tp_val,
    input  logic                   cfg_wr,
    input  logic                   cfg_enable,
    input  logic                   cfg_dir_eoi,
    input  logic [VW-1:0]          cfg_spur,
    output logic                   irq_out,
    output logic [VW-1:0]          ack_vec,
    output logic                   ack_real,
    output logic                   eoi_bcast,
    output logic [VW-1:0]          eoi_bcast_vec
);
    localparam int NVEC = 1 << VW;
    localparam int LW   = VW - PRI_CLASS_W;

    logic [NVEC-1:0] req_q, svc_q, lvl_q;
    logic [VW-1:0]   task_pri_q;
    cfg_flags_t      cfg_q;
    logic [VW-1:0]   spur_q;

    logic            req_found, svc_found;
    logic [VW-1:0]   req_top, svc_top;
    logic [VW-1:0]   cur_pri;
    logic            pending, offer;
    logic            take_en, retire_en, bcast_d;

    vec_msb_find #(.NBITS(NVEC), .WORD(WORD)) u_req_find (
        .bits (req_q),
        .found(req_found),
        .idx  (req_top)
    );

    vec_msb_find #(.NBITS(NVEC), .WORD(WORD)) u_svc_find (
        .bits (svc_q),
        .found(svc_found),
        .idx  (svc_top)
    );

    prio_eval #(.VW(VW)) u_eval (
        .enable   (cfg_q.enable),
        .task_pri (task_pri_q),
        .svc_found(svc_found),
        .svc_cls  (svc_top[VW-1:LW]),
        .req_found(req_found),
        .req_cls  (req_top[VW-1:LW]),
        .cur_pri  (cur_pri),
        .pending  (pending),
        .offer    (offer)
    );

    vec_bank #(.NBITS(NVEC), .IW(VW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_req),
        .set_idx   (set_vec),
        .set_lvl   (set_level),
        .take_en   (take_en),
        .take_idx  (req_top),
        .retire_en (retire_en),
        .retire_idx(svc_top),
        .req_q     (req_q),
        .svc_q     (svc_q),
        .lvl_q     (lvl_q)
    );

    // Acknowledge and end-of-interrupt decisions for this cycle.
    always_comb begin
        irq_out   = offer;
        take_en   = ack & offer;
        ack_real  = take_en;
        ack_vec   = offer ? req_top : spur_q;
        retire_en = eoi & svc_found;
        bcast_d   = retire_en & lvl_q[svc_top] & ~cfg_q.dir_eoi;
    end

    // Task priority register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            task_pri_q <= '0;
        end else if (tp_wr) begin
            task_pri_q <= {tp_val, {LW{1'b0}}};
        end
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            spur_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.enable  <= cfg_enable;
            cfg_q.dir_eoi <= cfg_dir_eoi;
            spur_q        <= cfg_spur;
        end
    end

    // Registered broadcast pulse and its vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_bcast     <= 1'b0;
            eoi_bcast_vec <= '0;
        end else begin
            eoi_bcast <= bcast_d;
            if (bcast_d) begin
                eoi_bcast_vec <= svc_top;
            end
        end
    end

    logic unused_pri;
    assign unused_pri = ^{cur_pri, pending};
endmodule

// File: rtl/irq_prio_core_chk.sv
// Module: irq_prio_core_chk
// Property checker for irq_prio_core, attached with bind. It watches the
// ports and the array state of the core.
module irq_prio_core_chk #(
    parameter int VW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               set_req,
    input logic [VW-1:0]      set_vec,
    input logic               set_level,
    input logic               ack,
    input logic               eoi,
    input logic               tp_wr,
    input logic [3:0]         tp_val,
    input logic               irq_out,
    input logic [VW-1:0]      ack_vec,
    input logic               ack_real,
    input logic               eoi_bcast,
    input logic [(1<<VW)-1:0] req_q,
    input logic [(1<<VW)-1:0] svc_q,
    input logic [(1<<VW)-1:0] lvl_q,
    input logic [VW-1:0]      task_pri_q,
    input logic               cfg_en
);
    localparam int LW = VW - 4;

    AST_SET_WRITES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> req_q[$past(set_vec)] && (lvl_q[$past(set_vec)] == $past(set_level))); // R2
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (cfg_en && (req_q != '0))); // R3
    AST_ACK_MOVES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_real && !(set_req && set_vec == ack_vec))
        |=> (svc_q[$past(ack_vec)] && !req_q[$past(ack_vec)])); // R6
    AST_SPURIOUS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ack_real && !set_req && !eoi) |=> ($stable(req_q) && $stable(svc_q))); // R7
    AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && svc_q != '0) |=> ($countones(svc_q) == $countones($past(svc_q)) - 1)); // R8
    AST_BCAST_AFTER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> $past(eoi)); // R9
    AST_EOI_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && svc_q == '0) |=> (!eoi_bcast && svc_q == '0)); // R10
    AST_TASK_PRI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tp_wr |=> (task_pri_q == {$past(tp_val), {LW{1'b0}}})); // R11
endmodule

bind irq_prio_core irq_prio_core_chk #(.VW(VW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_req   (set_req),
    .set_vec   (set_vec),
    .set_level (set_level),
    .ack       (ack),
    .eoi       (eoi),
    .tp_wr     (tp_wr),
    .tp_val    (tp_val),
    .irq_out   (irq_out),
    .ack_vec   (ack_vec),
    .ack_real  (ack_real),
    .eoi_bcast (eoi_bcast),
    .req_q     (req_q),
    .svc_q     (svc_q),
    .lvl_q     (lvl_q),
    .task_pri_q(task_pri_q),
    .cfg_en    (cfg_q.enable)
);

// File: tb/tb_irq_prio_core.sv
// Directed bench for irq_prio_core. Inputs are driven at falling edges.
// Combinational outputs are read 1 ns after driving, and registered
// results are read at the next falling edge.
module tb_irq_prio_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_req = 1'b0, set_level = 1'b0;
    logic [7:0] set_vec = '0;
    logic       ack = 1'b0, eoi = 1'b0, tp_wr = 1'b0, cfg_wr = 1'b0;
    logic [3:0] tp_val = '0;
    logic       cfg_enable = 1'b0, cfg_dir_eoi = 1'b0;
    logic [7:0] cfg_spur = '0;
    logic       irq_out, ack_real, eoi_bcast;
    logic [7:0] ack_vec, eoi_bcast_vec;

    int n_chk = 0;
    int n_err = 0;

    irq_prio_core dut (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .set_vec(set_vec),
        .set_level(set_level), .ack(ack), .eoi(eoi), .tp_wr(tp_wr),
        .tp_val(tp_val), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
        .cfg_dir_eoi(cfg_dir_eoi), .cfg_spur(cfg_spur), .irq_out(irq_out),
        .ack_vec(ack_vec), .ack_real(ack_real), .eoi_bcast(eoi_bcast),
        .eoi_bcast_vec(eoi_bcast_vec)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_req(input logic [7:0] v, input logic lvl);
        @(negedge clk); set_req = 1'b1; set_vec = v; set_level = lvl;
        @(negedge clk); set_req = 1'b0; #1;
    endtask

    task automatic do_ack(output logic [7:0] v, output logic r);
        @(negedge clk); ack = 1'b1; #1; v = ack_vec; r = ack_real;
        @(negedge clk); ack = 1'b0; #1;
    endtask

    task automatic do_eoi(output logic b, output logic [7:0] bv);
        @(negedge clk); eoi = 1'b1;
        @(negedge clk); eoi = 1'b0; #1; b = eoi_bcast; bv = eoi_bcast_vec;
    endtask

    task automatic put_cfg(input logic en, input logic de, input logic [7:0] sp);
        @(negedge clk); cfg_wr = 1'b1; cfg_enable = en; cfg_dir_eoi = de; cfg_spur = sp;
        @(negedge clk); cfg_wr = 1'b0; #1;
    endtask

    task automatic put_tp(input logic [3:0] v);
        @(negedge clk); tp_wr = 1'b1; tp_val = v;
        @(negedge clk); tp_wr = 1'b0; #1;
    endtask

    task automatic t_reset();
        logic [7:0] v; logic r;
        chk("R1 irq after reset", irq_out, 0);
        chk("R1 bcast after reset", eoi_bcast, 0);
        do_ack(v, r);
        chk("R1 ack_real after reset", r, 0);
        chk("R7 spurious after reset", v, 8'h00);
    endtask

    task automatic t_enable();
        logic [7:0] v, bv; logic r, b;
        put_req(8'h40, 1'b0);
        chk("R3 disabled no irq", irq_out, 0);
        put_cfg(1'b1, 1'b0, 8'hFF);
        chk("R3 enabled irq", irq_out, 1);
        do_ack(v, r);
        chk("R6 ack vector", v, 8'h40);
        chk("R6 ack real", r, 1);
        do_eoi(b, bv);
        chk("R9 edge vector no bcast", b, 0);
        chk("R3 empty no irq", irq_out, 0);
    endtask

    task automatic t_order();
        logic [7:0] v, bv; logic r, b;
        put_req(8'h41, 1'b0);
        put_req(8'h92, 1'b0);
        do_ack(v, r);
        chk("R4 highest first", v, 8'h92);
        chk("R5 lower class held", irq_out, 0);
        do_ack(v, r);
        chk("R7 held ack not real", r, 0);
        chk("R7 held ack spurious", v, 8'hFF);
        do_eoi(b, bv);
        chk("R8 eoi releases", irq_out, 1);
        do_ack(v, r);
        chk("R4 next vector", v, 8'h41);
        do_eoi(b, bv);
        put_req(8'h95, 1'b0);
        do_ack(v, r);
        put_req(8'h93, 1'b0);
        chk("R5 same class held", irq_out, 0);
        do_eoi(b, bv);
        chk("R5 released after eoi", irq_out, 1);
        do_ack(v, r);
        chk("R5 same class taken", v, 8'h93);
        do_eoi(b, bv);
    endtask

    task automatic t_bcast();
        logic [7:0] v, bv; logic r, b;
        put_req(8'h77, 1'b1);
        do_ack(v, r);
        do_eoi(b, bv);
        chk("R9 level bcast", b, 1);
        chk("R9 bcast vector", bv, 8'h77);
        @(negedge clk); #1;
        chk("R9 bcast one cycle", eoi_bcast, 0);
        put_cfg(1'b1, 1'b1, 8'hFF);
        put_req(8'h66, 1'b1);
        do_ack(v, r);
        do_eoi(b, bv);
        chk("R9 directed suppresses", b, 0);
        put_cfg(1'b1, 1'b0, 8'hFF);
        put_req(8'h88, 1'b1);
        put_req(8'h88, 1'b0);
        do_ack(v, r);
        do_eoi(b, bv);
        chk("R2 edge clears level", b, 0);
    endtask

    task automatic t_eoi_empty();
        logic [7:0] v, bv; logic r, b;
        put_req(8'h50, 1'b0);
        do_eoi(b, bv);
        chk("R10 empty eoi no bcast", b, 0);
        chk("R10 request still offered", irq_out, 1);
        do_ack(v, r);
        chk("R10 ack after empty eoi", v, 8'h50);
        do_eoi(b, bv);
    endtask

    task automatic t_task_pri();
        logic [7:0] v, bv; logic r, b;
        put_tp(4'h5);
        put_req(8'h50, 1'b0);
        chk("R11 task pri holds class 5", irq_out, 0);
        put_req(8'h61, 1'b0);
        chk("R11 class 6 passes", irq_out, 1);
        do_ack(v, r);
        chk("R11 ack class 6", v, 8'h61);
        do_eoi(b, bv);
        do_ack(v, r);
        chk("R11 held by task pri", r, 0);
        put_tp(4'h4);
        chk("R11 lowered task pri", irq_out, 1);
        do_ack(v, r);
        chk("R11 ack after lower", v, 8'h50);
        do_eoi(b, bv);
        put_tp(4'h0);
    endtask

    task automatic t_set_wins();
        logic [7:0] v, bv; logic r, b;
        put_req(8'h30, 1'b0);
        @(negedge clk); ack = 1'b1; set_req = 1'b1; set_vec = 8'h30; set_level = 1'b0; #1;
        chk("R12 ack vector", ack_vec, 8'h30);
        chk("R12 ack real", ack_real, 1);
        @(negedge clk); ack = 1'b0; set_req = 1'b0; #1;
        chk("R12 held by own class", irq_out, 0);
        do_eoi(b, bv);
        chk("R12 still requested", irq_out, 1);
        do_ack(v, r);
        chk("R12 taken again", v, 8'h30);
        do_eoi(b, bv);
    endtask

    task automatic t_reset_mid();
        put_req(8'hA0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; #1;
        chk("R1 reset clears enable", irq_out, 0);
        put_cfg(1'b1, 1'b0, 8'hFF);
        chk("R1 reset clears requests", irq_out, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_enable();
        t_order();
        t_bcast();
        t_eoi_empty();
        t_task_pri();
        t_set_wins();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule